// File: doc/BRIEF.md
# Interrupt Priority and Acknowledge Controller

This block sits between seven interrupt request lines and a 68000-style CPU. It reduces the active-low request lines to a single 3-bit active-low priority level for the CPU's interrupt pins. When several requests are active, the highest one wins. During an interrupt-acknowledge bus cycle, it turns the function code and the level on address bits A03..A01 into one active-low acknowledge strobe per level. For the upper levels it also asks the CPU to fetch an autovector.

A push-button abort source is built in at the top level. The raw button is synchronized and filtered by a stable-count debouncer. A qualified press sets a sticky flag that holds the level-7 request active until the CPU acknowledges level 7. Two decoded status outputs report whether the current access is a supervisor access and whether it is a program fetch. They are intended for debug probing.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the abort flag is clear. With every request line high and the address strobe high, the IPL output reads 3'b111, all seven acknowledge strobes are high and the autovector request is high.
- R2: `irq_n[k]` stands for level k+1. The IPL output is the bitwise inverse of the highest active level, so level 6 alone gives 3'b001. With nothing active it is 3'b111.
- R3: With function code 3'b111 and the address strobe low, a level L from 1 to 7 on `addr_lvl` drives `iack_n[L-1]` low and leaves the other strobes high. Level 0 drives no strobe.
- R4: When the address strobe is high, or the function code is anything other than 3'b111, every acknowledge strobe stays high.
- R5: An acknowledge at level 4, 5, 6 or 7 drives `vpa_n` low.
- R6: `vpa_n` stays high for acknowledges at levels 1 to 3 and whenever no acknowledge is in progress.
- R7: A button press that lasts fewer than DEBOUNCE_CYCLES synchronized cycles is ignored, and the IPL output is unchanged.
- R8: A press held long enough sets the abort flag. While the flag is set, the IPL output is 3'b000 whatever the other requests are, including after the button is released.
- R9: The abort flag clears on the clock edge at which `iack_n[6]` is low. Acknowledges at other levels leave it set. If a new qualified press arrives on the same edge, the flag stays set.
- R10: `super_o` is high for function codes 5 and 6. `prog_o` is high for function codes 2 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 7 | Active-low requests; bit k is level k+1 |
| fc | input | 3 | CPU function code |
| addr_lvl | input | 3 | Address bits A03..A01 |
| as_n | input | 1 | Address strobe, active low |
| abort_btn | input | 1 | Raw abort button, high while pressed |
| ipl_n | output | 3 | Active-low priority level to the CPU |
| iack_n | output | 7 | Active-low acknowledge strobe per level |
| vpa_n | output | 1 | Active-low autovector request |
| super_o | output | 1 | Supervisor data or program access |
| prog_o | output | 1 | Program-space access |

## Verification
The bench targets the corner cases that a decoder variant would get wrong:
- Several simultaneous requests: an encoder that favours the lowest line would present the wrong level.
- Acknowledge level 0 and acknowledges with the address strobe high: a careless decoder would still fire a strobe.
- The boundary between levels 3 and 4: an off-by-one autovector threshold would assert or drop `vpa_n` on the wrong level.
- The abort path with a glitch just shorter than the filter window: a filter that is too short would latch it.
- A level-6 acknowledge while the flag is set: a flag wired to the wrong strobe would clear early.
- A level-7 acknowledge: a missing clear path would keep the CPU at level 7 forever.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NUM_LVL = 7;
  localparam int LVL_W   = 3;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [2:0] {
    FC_UNDEF0   = 3'd0,
    FC_USR_DATA = 3'd1,
    FC_USR_PROG = 3'd2,
    FC_UNDEF3   = 3'd3,
    FC_UNDEF4   = 3'd4,
    FC_SUP_DATA = 3'd5,
    FC_SUP_PROG = 3'd6,
    FC_IACK     = 3'd7
  } fc_e;

  // Highest active level; bit k of req stands for level k+1, 0 means none.
  function automatic lvl_t top_level(input logic [NUM_LVL-1:0] req);
    lvl_t lvl;
    lvl = '0;
    for (int i = 0; i < NUM_LVL; i++)
      if (req[i]) lvl = lvl_t'(i + 1);
    return lvl;
  endfunction

  function automatic logic is_super(input logic [2:0] code);
    return (code == FC_SUP_DATA) || (code == FC_SUP_PROG);
  endfunction

  function automatic logic is_prog(input logic [2:0] code);
    return (code == FC_USR_PROG) || (code == FC_SUP_PROG);
  endfunction
endpackage

// File: rtl/irq_level_enc.sv
module irq_level_enc
  import irq_prio_pkg::*;
(
  input  logic [NUM_LVL-1:0] req_act,
  output logic [LVL_W-1:0]   ipl_n
);
  lvl_t win_lvl;

  always_comb begin
    win_lvl = top_level(req_act);
    ipl_n   = ~win_lvl;
  end
endmodule

// File: rtl/iack_decode.sv
module iack_decode
  import irq_prio_pkg::*;
#(
  parameter int AUTOVEC_MIN_LVL = 4
) (
  input  logic [2:0]         fc,
  input  logic [LVL_W-1:0]   addr_lvl,
  input  logic               as_n,
  output logic [NUM_LVL-1:0] iack_n,
  output logic               vpa_n
);
  logic                ack_cycle;
  logic [NUM_LVL-1:0]  auto_hit;

  assign ack_cycle = (fc == FC_IACK) && !as_n;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    assign iack_n[g] = ~(ack_cycle && (addr_lvl == lvl_t'(g + 1)));
    if (g + 1 >= AUTOVEC_MIN_LVL) begin : g_auto
      assign auto_hit[g] = ~iack_n[g];
    end else begin : g_vect
      assign auto_hit[g] = 1'b0;
    end
  end

  assign vpa_n = ~|auto_hit;
endmodule

// File: rtl/abort_latch.sv
module abort_latch #(
  parameter int DEBOUNCE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn,
  input  logic ack_top,
  output logic flag,
  output logic set_evt
);
  localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);

  logic [1:0]       sync_q;
  logic             filt_q;
  logic [CNT_W-1:0] cnt_q;
  logic             differ;
  logic             commit;

  assign differ  = sync_q[1] ^ filt_q;
  assign commit  = differ && (cnt_q == CNT_W'(DEBOUNCE_CYCLES - 1));
  assign set_evt = commit && sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
      flag   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], btn};
      if (!differ) begin
        cnt_q <= '0;
      end else if (commit) begin
        cnt_q  <= '0;
        filt_q <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (set_evt)      flag <= 1'b1;
      else if (ack_top) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 8,
  parameter int AUTOVEC_MIN_LVL = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] irq_n,
  input  logic [2:0] fc,
  input  logic [2:0] addr_lvl,
  input  logic       as_n,
  input  logic       abort_btn,
  output logic [2:0] ipl_n,
  output logic [6:0] iack_n,
  output logic       vpa_n,
  output logic       super_o,
  output logic       prog_o
);
  logic               abort_flag;
  logic               abort_set;
  logic [NUM_LVL-1:0] req_act;

  assign req_act = ~irq_n | {abort_flag, {(NUM_LVL-1){1'b0}}};

  irq_level_enc u_enc (
    .req_act (req_act),
    .ipl_n   (ipl_n)
  );

  iack_decode #(.AUTOVEC_MIN_LVL(AUTOVEC_MIN_LVL)) u_dec (
    .fc       (fc),
    .addr_lvl (addr_lvl),
    .as_n     (as_n),
    .iack_n   (iack_n),
    .vpa_n    (vpa_n)
  );

  abort_latch #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_abort (
    .clk     (clk),
    .rst_n   (rst_n),
    .btn     (abort_btn),
    .ack_top (~iack_n[NUM_LVL-1]),
    .flag    (abort_flag),
    .set_evt (abort_set)
  );

  assign super_o = is_super(fc);
  assign prog_o  = is_prog(fc);
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] irq_n,
  input logic [2:0] fc,
  input logic       as_n,
  input logic [2:0] ipl_n,
  input logic [6:0] iack_n,
  input logic       vpa_n,
  input logic       abort_flag,
  input logic       abort_set
);
  assert_iack_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~iack_n));

  assert_no_iack_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (as_n || fc != 3'b111) |-> (iack_n == 7'h7f));

  assert_vpa_upper_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !vpa_n |-> (iack_n[6:3] != 4'hf));

  assert_vpa_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_n[6:3] != 4'hf) |-> !vpa_n);

  assert_idle_ipl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (&irq_n && !abort_flag) |-> (ipl_n == 3'b111));

  assert_flag_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_flag |-> (ipl_n == 3'b000));

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_flag && !iack_n[6] && !abort_set) |=> !abort_flag);

  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_flag && iack_n[6]) |=> abort_flag);
endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_n      (irq_n),
  .fc         (fc),
  .as_n       (as_n),
  .ipl_n      (ipl_n),
  .iack_n     (iack_n),
  .vpa_n      (vpa_n),
  .abort_flag (abort_flag),
  .abort_set  (abort_set)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DB         = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] irq_n = 7'h7f;
  logic [2:0] fc = 3'd0;
  logic [2:0] addr_lvl = 3'd0;
  logic       as_n = 1'b1;
  logic       abort_btn = 1'b0;
  logic [2:0] ipl_n;
  logic [6:0] iack_n;
  logic       vpa_n;
  logic       super_o;
  logic       prog_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic exp_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl #(.DEBOUNCE_CYCLES(DB), .AUTOVEC_MIN_LVL(4)) i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .fc(fc), .addr_lvl(addr_lvl),
    .as_n(as_n), .abort_btn(abort_btn), .ipl_n(ipl_n), .iack_n(iack_n),
    .vpa_n(vpa_n), .super_o(super_o), .prog_o(prog_o)
  );

  function automatic logic [2:0] want_ipl(input logic [6:0] rq, input logic flg);
    if (flg) return 3'b000;
    for (int lv = 7; lv >= 1; lv--)
      if (!rq[lv-1]) return ~3'(lv);
    return 3'b111;
  endfunction

  function automatic logic [6:0] want_iack(input logic [2:0] f, input logic [2:0] a, input logic s);
    logic [6:0] r;
    r = 7'h7f;
    if (f == 3'b111 && !s && a != 3'd0) r[a-1] = 1'b0;
    return r;
  endfunction

  function automatic logic want_vpa(input logic [2:0] f, input logic [2:0] a, input logic s);
    return !(f == 3'b111 && !s && a >= 3'd4);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " R2 ipl"},  32'(ipl_n),  32'(want_ipl(irq_n, exp_flag)));
    check({tag, " R3 iack"}, 32'(iack_n), 32'(want_iack(fc, addr_lvl, as_n)));
    check({tag, " R5 vpa"},  32'(vpa_n),  32'(want_vpa(fc, addr_lvl, as_n)));
    check({tag, " R10 super"}, 32'(super_o), 32'(fc == 3'd5 || fc == 3'd6));
    check({tag, " R10 prog"},  32'(prog_o),  32'(fc == 3'd2 || fc == 3'd6));
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    cycles(3);
    #1;
    check("R1 reset ipl", 32'(ipl_n), 32'h7);
    check("R1 reset iack", 32'(iack_n), 32'h7f);
    check("R1 reset vpa", 32'(vpa_n), 32'h1);
    rst_n = 1'b1;
    cycles(2);

    // directed: priority of several lines
    irq_n = 7'b1011010; #1; check("R2 multi 6 wins", 32'(ipl_n), 32'h1);
    irq_n = 7'b1111110; #1; check("R2 level1 only", 32'(ipl_n), 32'h6);
    irq_n = 7'h7f;
    // directed: ack level 0, ack with strobe high, boundary 3/4
    fc = 3'b111; as_n = 1'b0; addr_lvl = 3'd0; #1;
    check("R3 level0 no strobe", 32'(iack_n), 32'h7f);
    addr_lvl = 3'd3; #1;
    check("R6 level3 no vpa", 32'(vpa_n), 32'h1);
    check("R3 level3 strobe", 32'(iack_n), 32'h7b);
    addr_lvl = 3'd4; #1;
    check("R5 level4 vpa", 32'(vpa_n), 32'h0);
    as_n = 1'b1; #1;
    check("R4 strobe high", 32'(iack_n), 32'h7f);
    fc = 3'd6; as_n = 1'b0; #1;
    check("R4 non-iack fc", 32'(iack_n), 32'h7f);
    as_n = 1'b1; fc = 3'd0;
    cycles(1);

    // random sweep of the combinational paths (flag stays clear)
    for (int i = 0; i < 400; i++) begin
      irq_n    = 7'($urandom);
      fc       = 3'($urandom);
      addr_lvl = 3'($urandom);
      as_n     = 1'($urandom);
      #1;
      check_all("rand");
      cycles(1);
    end
    irq_n = 7'h7f; fc = 3'd0; as_n = 1'b1; addr_lvl = 3'd0;
    cycles(2);

    // R7: short glitch ignored
    abort_btn = 1'b1; cycles(DB - 3); abort_btn = 1'b0;
    cycles(DB + 6); #1;
    check("R7 glitch ignored", 32'(ipl_n), 32'h7);

    // R8: held press sets flag
    abort_btn = 1'b1; cycles(DB + 6); #1;
    exp_flag = 1'b1;
    check("R8 flag sets", 32'(ipl_n), 32'h0);
    abort_btn = 1'b0; irq_n = 7'b1111011; cycles(DB + 6); #1;
    check("R8 flag held after release", 32'(ipl_n), 32'h0);
    irq_n = 7'h7f;

    // R9: level-6 acknowledge leaves flag set
    fc = 3'b111; addr_lvl = 3'd6; as_n = 1'b0; #1;
    check("R9 iack6 strobe", 32'(iack_n), 32'h5f);
    cycles(1);
    as_n = 1'b1; fc = 3'd0; #1;
    check("R9 flag survives iack6", 32'(ipl_n), 32'h0);
    cycles(1);

    // R9: level-7 acknowledge clears flag
    fc = 3'b111; addr_lvl = 3'd7; as_n = 1'b0; #1;
    check("R9 iack7 strobe", 32'(iack_n), 32'h3f);
    check("R5 iack7 vpa", 32'(vpa_n), 32'h0);
    cycles(1);
    as_n = 1'b1; fc = 3'd0; exp_flag = 1'b0; #1;
    check("R9 flag cleared", 32'(ipl_n), 32'h7);
    cycles(3); #1;
    check("R9 stays clear", 32'(ipl_n), 32'h7);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule